// File: doc/BRIEF.md
# Three-Level Sequential Bus Trigger

This block watches a data word on a processor bus and raises breakpoint events. Three match units, called A, B and C, each hold a compare value and a don't-care mask. A unit matches on a cycle where the bus-valid input is high, the unit is enabled, and every bit that is not masked equals the compare value. When a unit fires, it flips its own event pin and updates a sticky hit flag. The halt request output is then raised or left alone, depending on the mode.

The block has two modes. In independent mode any unit that fires raises the halt request. In sequential mode the units form an arming chain: B can fire only after A has fired, C only after B, and only C raises the halt. A stage whose unit is disabled is skipped, and the chain treats it as already satisfied. The halt request stays high until software writes the clear bit. That write also returns the chain to waiting for A and clears the sticky hit flags. A small word-wide register port programs the units and reads back their configuration and status.

Top module: `bus_seq_trigger`

## Requirements
- R1: An enabled unit matches when bus_valid is high and ((bus_data ^ value) & ~mask) == 0. A mask bit of 1 marks that bit as don't-care. In independent mode every matching unit fires. Outputs update at the clock edge that samples the bus word.
- R2: A unit whose enable bit is 0 never fires, whatever the bus carries.
- R3: No unit fires on a cycle where bus_valid is low.
- R4: Each firing of unit A, B or C inverts evt_pin[0], evt_pin[1] or evt_pin[2] respectively. Event pins are never affected by anything else except reset.
- R5: In independent mode (seq bit 0) a firing of any unit sets halt_req.
- R6: In sequential mode (seq bit 1) only the earliest enabled stage at or after the current stage can fire. A stage becomes satisfied when it fires, and this advances at most one stage per cycle. A bus word that matches a later stage before it is armed has no effect.
- R7: In sequential mode only a firing of C sets halt_req. Firings of A or B only advance the chain. A disabled stage is skipped.
- R8: halt_req stays high until a clear. A clear is a write to the control register with bit 4 set. The clear drops halt_req, zeroes the sticky hit flags and returns the chain to waiting for A. It takes priority over any firing in the same cycle, and that firing is then lost, including its pin toggle.
- R9: Register map on cfg_addr (3 bits), writes on cfg_we at the clock edge, read data combinational: 0 = control (bit0 seq, bits 3:1 enables of A,B,C, bit4 clear; reads back 0); 1 = status, read-only (bits 2:0 sticky hits A,B,C; bit3 halt_req; bits 5:4 chain stage 0..3, where 3 means chain finished); 2/3 = value/mask A; 4/5 = value/mask B; 6/7 = value/mask C. Unused read bits are 0.
- R10: In sequential mode, once C has fired (stage 3), no unit fires until a clear.
- R11: Reset (synchronous, active high) clears all registers, the event pins, halt_req, the sticky flags and the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for cfg_addr |
| bus_valid | input | 1 | Bus word qualifier |
| bus_data | input | DATA_W | Observed bus word |
| halt_req | output | 1 | Sticky halt request |
| evt_pin | output | 3 | Per-unit toggling event pins A, B, C |

## Verification
The bench builds the block with DATA_W = 8. With an 8-bit word, bus words drawn near the programmed values, with bits flipped under and outside the masks, land on exact matches, masked near-misses and one-bit misses often. Random reprogramming then reaches every chain stage, mode switches in the middle of a chain, and clears that coincide with matches. The directed cases pin down out-of-order words, stage skipping and the finished chain.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int NTRIG  = 3;
    localparam int ADDR_W = 3;
    localparam int CLR_BIT = 4;

    typedef logic [1:0] stage_t;
    localparam stage_t ST_DONE = 2'd3;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_STAT  = 3'd1,
        RA_VAL_A = 3'd2,
        RA_MSK_A = 3'd3,
        RA_VAL_B = 3'd4,
        RA_MSK_B = 3'd5,
        RA_VAL_C = 3'd6,
        RA_MSK_C = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [NTRIG-1:0] en;
        logic             seq;
    } ctrl_t;

    typedef struct packed {
        stage_t           stage;
        logic             halt;
        logic [NTRIG-1:0] sticky;
    } status_t;

    // earliest enabled stage at or after st; ST_DONE when none remains
    function automatic stage_t first_armed(stage_t st, logic [NTRIG-1:0] en);
        stage_t r;
        r = ST_DONE;
        for (int i = NTRIG - 1; i >= 0; i--) begin
            if (i >= int'(st) && en[i]) r = stage_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/trig_regs.sv
module trig_regs
    import trig_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output ctrl_t                         ctrl_o,
    output logic                          clr_o,
    output logic [NTRIG-1:0][DATA_W-1:0]  val_o,
    output logic [NTRIG-1:0][DATA_W-1:0]  msk_o
);

    logic ctrl_we;
    assign ctrl_we = we && (addr == RA_CTRL);
    assign clr_o   = ctrl_we && wdata[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
        end else if (ctrl_we) begin
            ctrl_o.seq <= wdata[0];
            ctrl_o.en  <= wdata[NTRIG:1];
        end
    end

    for (genvar t = 0; t < NTRIG; t++) begin : g_unit
        localparam logic [ADDR_W-1:0] VAL_ADDR = ADDR_W'(2 + 2 * t);
        localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(3 + 2 * t);

        always_ff @(posedge clk) begin
            if (rst) begin
                val_o[t] <= '0;
                msk_o[t] <= '0;
            end else if (we) begin
                if (addr == VAL_ADDR) val_o[t] <= wdata;
                if (addr == MSK_ADDR) msk_o[t] <= wdata;
            end
        end
    end

endmodule

// File: rtl/trig_match.sv
module trig_match #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic              en,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] mask,
    output logic              match
);

    logic [DATA_W-1:0] diff;
    assign diff  = (data ^ value) & ~mask;
    assign match = valid && en && (diff == '0);

    a_r3_idle_bus_no_match: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !match);

    a_r2_disabled_no_match: assert property (@(posedge clk) disable iff (rst)
        !en |-> !match);

endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             clr,
    input  logic [NTRIG-1:0] match,
    output logic [NTRIG-1:0] evt_o,
    output status_t          stat_o
);

    stage_t           armed;
    logic [NTRIG-1:0] hit;
    logic             halt_set;

    assign armed = first_armed(stat_o.stage, ctrl.en);

    always_comb begin
        hit = '0;
        if (!ctrl.seq) begin
            hit = match;
        end else if (armed != ST_DONE) begin
            hit[armed] = match[armed];
        end
        halt_set = ctrl.seq ? hit[NTRIG-1] : |hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o <= '0;
            evt_o  <= '0;
        end else if (clr) begin
            stat_o <= '0;
        end else begin
            evt_o         <= evt_o ^ hit;
            stat_o.sticky <= stat_o.sticky | hit;
            if (halt_set) stat_o.halt <= 1'b1;
            if (ctrl.seq && (|hit)) stat_o.stage <= armed + 2'd1;
        end
    end

    a_r8_halt_holds: assert property (@(posedge clk) disable iff (rst)
        stat_o.halt && !clr |=> stat_o.halt);

    a_r8_clear_resets: assert property (@(posedge clk) disable iff (rst)
        clr |=> (stat_o == '0));

    a_r6_single_stage: assert property (@(posedge clk) disable iff (rst)
        ctrl.seq |-> $onehot0(hit));

    a_r7_only_c_halts: assert property (@(posedge clk) disable iff (rst)
        ctrl.seq && !clr && !stat_o.halt && !match[NTRIG-1] |=> !stat_o.halt);

    a_r10_finished_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl.seq && stat_o.stage == ST_DONE && !clr |=> $stable(evt_o));

endmodule

// File: rtl/bus_seq_trigger.sv
module bus_seq_trigger
    import trig_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              bus_valid,
    input  logic [DATA_W-1:0] bus_data,
    output logic              halt_req,
    output logic [2:0]        evt_pin
);

    localparam int STAT_W = $bits(status_t);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t                        ctrl;
    logic                         clr;
    logic [NTRIG-1:0][DATA_W-1:0] val;
    logic [NTRIG-1:0][DATA_W-1:0] msk;
    logic [NTRIG-1:0]             match;
    status_t                      stat;

    trig_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl_o(ctrl), .clr_o(clr), .val_o(val), .msk_o(msk)
    );

    for (genvar t = 0; t < NTRIG; t++) begin : g_match
        trig_match #(.DATA_W(DATA_W)) u_match (
            .clk(clk), .rst(rst), .valid(bus_valid), .data(bus_data),
            .en(ctrl.en[t]), .value(val[t]), .mask(msk[t]), .match(match[t])
        );
    end

    trig_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .clr(clr), .match(match),
        .evt_o(evt_pin), .stat_o(stat)
    );

    assign halt_req = stat.halt;

    always_comb begin
        cfg_rdata = '0;
        case (reg_addr_e'(cfg_addr))
            RA_CTRL:  cfg_rdata[CTRL_W-1:0] = ctrl;
            RA_STAT:  cfg_rdata[STAT_W-1:0] = stat;
            RA_VAL_A: cfg_rdata = val[0];
            RA_MSK_A: cfg_rdata = msk[0];
            RA_VAL_B: cfg_rdata = val[1];
            RA_MSK_B: cfg_rdata = msk[1];
            RA_VAL_C: cfg_rdata = val[2];
            RA_MSK_C: cfg_rdata = msk[2];
            default:  cfg_rdata = '0;
        endcase
    end

    for (genvar t = 0; t < NTRIG; t++) begin : g_chk
        a_r4_pin_toggle_flags_hit: assert property (@(posedge clk) disable iff (rst)
            (evt_pin[t] != $past(evt_pin[t])) |-> stat.sticky[t]);
    end

endmodule

// File: tb/sim_bus_seq_trigger.sv
module sim_bus_seq_trigger;

    localparam int DW = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = 3'd1;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          bus_valid = 1'b0;
    logic [DW-1:0] bus_data = '0;
    logic          halt_req;
    logic [2:0]    evt_pin;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // reference state
    logic [DW-1:0] m_val [3];
    logic [DW-1:0] m_msk [3];
    logic          m_seq;
    logic [2:0]    m_en;
    logic [1:0]    m_stage;
    logic [2:0]    m_sticky;
    logic          m_halt;
    logic [2:0]    m_evt;

    bus_seq_trigger #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
        .bus_data(bus_data), .halt_req(halt_req), .evt_pin(evt_pin)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [DW-1:0] model_read(input logic [2:0] a);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            3'd0: r[3:0] = {m_en, m_seq};
            3'd1: r[5:0] = {m_stage, m_halt, m_sticky};
            3'd2: r = m_val[0];
            3'd3: r = m_msk[0];
            3'd4: r = m_val[1];
            3'd5: r = m_msk[1];
            3'd6: r = m_val[2];
            default: r = m_msk[2];
        endcase
        return r;
    endfunction

    function automatic logic [2:0] model_hits(input logic v, input logic [DW-1:0] d);
        logic [2:0] mt;
        logic [2:0] h;
        int armed;
        for (int i = 0; i < 3; i++)
            mt[i] = v && m_en[i] && (((d ^ m_val[i]) & ~m_msk[i]) == '0);
        h = '0;
        if (!m_seq) begin
            h = mt;
        end else begin
            armed = 3;
            for (int s = 2; s >= 0; s--)
                if (s >= int'(m_stage) && m_en[s]) armed = s;
            if (armed < 3) h[armed] = mt[armed];
        end
        return h;
    endfunction

    // one cycle: drive at negedge, update model, compare at next negedge
    task automatic cyc(input logic v, input logic [DW-1:0] d, input logic we,
                       input logic [2:0] a, input logic [DW-1:0] wd);
        logic [2:0] h;
        logic       clr;
        bus_valid = v; bus_data = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        h   = model_hits(v, d);
        clr = we && (a == 3'd0) && wd[4];
        if (clr) begin
            m_stage = 2'd0; m_sticky = '0; m_halt = 1'b0;
        end else begin
            m_evt    = m_evt ^ h;
            m_sticky = m_sticky | h;
            if (m_seq ? h[2] : (|h)) m_halt = 1'b1;
            if (m_seq && (|h)) begin
                for (int i = 0; i < 3; i++) if (h[i]) m_stage = 2'(i + 1);
            end
        end
        if (we) begin
            case (a)
                3'd0: begin m_seq = wd[0]; m_en = wd[3:1]; end
                3'd1: ;
                3'd2: m_val[0] = wd;
                3'd3: m_msk[0] = wd;
                3'd4: m_val[1] = wd;
                3'd5: m_msk[1] = wd;
                3'd6: m_val[2] = wd;
                default: m_msk[2] = wd;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        chk("R5/R7/R8 halt_req", 32'(halt_req), 32'(m_halt));
        chk("R4 evt_pin", 32'(evt_pin), 32'(m_evt));
        chk("R9 cfg_rdata", 32'(cfg_rdata), 32'(model_read(a)));
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] wd);
        cyc(1'b0, '0, 1'b1, a, wd);
    endtask

    task automatic bus(input logic [DW-1:0] d);
        cyc(1'b1, d, 1'b0, 3'd1, '0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin m_val[i] = '0; m_msk[i] = '0; end
        m_seq = 0; m_en = '0; m_stage = '0; m_sticky = '0; m_halt = 0; m_evt = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 halt after reset", 32'(halt_req), 32'd0);
        chk("R11 evt after reset", 32'(evt_pin), 32'd0);
        chk("R11 status after reset", 32'(cfg_rdata), 32'd0);

        // independent masked matching
        wr(3'd2, 8'h5A); wr(3'd3, 8'h0F);
        bus(8'h50);                                   // R2: A not yet enabled
        chk("R2 disabled unit silent", 32'(evt_pin), 32'd0);
        wr(3'd0, 8'b0000_0010);                       // enable A, independent
        bus(8'hDA);                                   // bit7 differs outside mask
        chk("R1 unmasked bit differs", 32'(evt_pin), 32'd0);
        cyc(1'b0, 8'h53, 1'b0, 3'd1, '0);             // valid low
        chk("R3 valid low ignored", 32'(evt_pin), 32'd0);
        chk("R3 status untouched", 32'(cfg_rdata), 32'd0);
        bus(8'h53);                                   // match under mask
        chk("R1 masked match toggles A", 32'(evt_pin), 32'd1);
        chk("R5 independent halt", 32'(halt_req), 32'd1);
        bus(8'h00);
        chk("R8 halt held", 32'(halt_req), 32'd1);

        // sequential chain A->B->C
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h11); wr(3'd4, 8'h22); wr(3'd6, 8'h33);
        wr(3'd5, 8'h00); wr(3'd7, 8'h00);
        wr(3'd0, 8'b0001_1111);                       // clear, seq, all enabled
        chk("R8 clear drops halt", 32'(halt_req), 32'd0);
        bus(8'h33); bus(8'h22);
        chk("R6 out of order ignored", 32'(evt_pin), 32'd1);
        bus(8'h11);
        chk("R7 A advances no halt", 32'(halt_req), 32'd0);
        chk("R4 A toggles pin0", 32'(evt_pin), 32'd0);
        bus(8'h33);
        chk("R6 C before B ignored", 32'(cfg_rdata), 32'h11);
        bus(8'h22);
        chk("R4 B toggles pin1", 32'(evt_pin), 32'd2);
        bus(8'h33);
        chk("R7 C raises halt", 32'(halt_req), 32'd1);
        chk("R9 status finished", 32'(cfg_rdata), 32'h3F);
        bus(8'h11);
        chk("R10 finished chain quiet", 32'(evt_pin), 32'd6);

        // skipped stage and clear priority
        wr(3'd0, 8'b0001_1011);                       // clear, seq, A and C
        bus(8'h11);
        bus(8'h33);
        chk("R7 disabled B skipped", 32'(halt_req), 32'd1);
        cyc(1'b1, 8'h11, 1'b1, 3'd0, 8'b0001_1011);   // clear while A matches
        chk("R8 clear wins over hit", 32'(evt_pin), 32'd6 ^ 32'd1 ^ 32'd4);
        cfg_addr = 3'd1; #1;
        chk("R8 status cleared", 32'(cfg_rdata), 32'd0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic [DW-1:0] d;
            int k;
            k = int'($urandom % 3);
            if ($urandom % 4 != 0) d = m_val[k] ^ (DW'($urandom) & m_msk[k]);
            else d = DW'($urandom);
            if ($urandom % 8 == 0) d = d ^ DW'(1 << ($urandom % DW));
            if ($urandom % 10 == 0) begin
                logic [2:0] a;
                logic [DW-1:0] wd;
                a  = 3'($urandom);
                wd = DW'($urandom);
                if (a == 3'd0 && ($urandom % 3 != 0)) wd[4] = 1'b0;
                if (a == 3'd3 || a == 3'd5 || a == 3'd7) wd = wd & DW'($urandom);
                cyc($urandom % 5 != 0, d, 1'b1, a, wd);
            end else begin
                cyc($urandom % 5 != 0, d, 1'b0, 3'($urandom), '0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule